// File: doc/BRIEF.md
# Dual-Channel Serial DAC Code Front End

This block is the digital side of a two-channel serial-input converter. A host shifts a data word in, most significant bit first, on a serial data pin under a serial clock. Each serial clock edge counts only while the active-low select pin is low. Each channel has its own active-low load pin. While that pin is low, the channel's code register is transparent to the shared shift register. On the pin's rising edge the register captures the current value and then holds it.

An active-low clear pin overrides both load pins. While clear is low, both codes are forced to zero or to mid-scale, and a strap pin picks which. When clear is released the forced code stays until a later load. A power-down pin is passed to a flag output and has no other effect.

All pins are asynchronous to the system clock. Each pin is synchronised. The serial clock is edge-detected. The level-sensitive load and clear behaviour is then reproduced with flops. The word length is a parameter, and the 12-bit and 10-bit builds are both supported.

Top module: `dual_dac_frontend`

## Requirements
- R1: On each rising edge of sclk_i while cs_ni is low, the shift register moves one place toward the MSB and takes sdi_i into bit 0. After DATA_W edges it holds the word sent MSB first.
- R2: Rising edges of sclk_i while cs_ni is high leave the shift register unchanged. A later load shows the earlier word.
- R3: While ld_a_ni (or ld_b_ni) is low and clr_ni is high, code_a_o (or code_b_o) follows the shift register. After the load pin rises, the code keeps the captured value.
- R4: While a channel's load pin is high, its code holds through any serial clocking or select activity. The other channel's load does not change it.
- R5: While clr_ni is low, both codes equal 1 followed by DATA_W-1 zeros (0x800 at 12 bits, 0x200 at 10 bits) if mid_sel_i is high, and zero if it is low. The forced code remains after clr_ni rises until a load.
- R6: Clear has priority. A low load pin during clear does not replace the forced code.
- R7: Clear does not alter the shift register. A load after clear shows the word shifted in before it.
- R8: pd_o is the inverse of pd_ni. A low pd_ni changes neither the codes nor the shift register.
- R9: DATA_W = 10 gives the same behaviour, with the low 10 bits of the serial stream and a 10-bit mid-scale code.
- R10: After rst_ni both codes are zero and pd_o is low.
- R11: If a load pin is low while words are clocked in, the code follows every intermediate shift. This is a protocol violation that the bench's monitor counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples all pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data pin |
| cs_ni | input | 1 | Active-low select, gates sclk_i |
| ld_a_ni | input | 1 | Active-low load, channel A |
| ld_b_ni | input | 1 | Active-low load, channel B |
| clr_ni | input | 1 | Active-low clear of both codes |
| mid_sel_i | input | 1 | Clear code strap: 1 mid-scale, 0 zero |
| pd_ni | input | 1 | Active-low power-down pin |
| code_a_o | output | DATA_W | Channel A code |
| code_b_o | output | DATA_W | Channel B code |
| pd_o | output | 1 | Power-down flag |

## Verification
Every cycle, the assertions check these rules against the synchronised pin values:
- the shift register moves only on a qualified serial edge, and then by exactly one bit;
- each code holds while its load is high and clear is released;
- each code tracks the shift register while its load is low;
- clear forces the strap-selected code even while a load is low.

Some behaviours can only be shown by the bench's scenarios, because they concern the pins and not the state inside the flops:
- that gated edges leave no trace in a later load;
- that clear and power-down preserve the shift contents;
- that the 10-bit build lines up with the low bits of the stream;
- that a transparent channel exposes partial words.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef struct packed {
    logic sclk;
    logic sdi;
    logic cs_n;
    logic ld_a_n;
    logic ld_b_n;
    logic clr_n;
    logic mid_sel;
    logic pd_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sclk: 1'b0, sdi: 1'b0, cs_n: 1'b1, ld_a_n: 1'b1,
                                  ld_b_n: 1'b1, clr_n: 1'b1, mid_sel: 1'b0, pd_n: 1'b1};

  localparam int NUM_CH = 2;

endpackage

// File: rtl/dac_fe_pin_sync.sv
module dac_fe_pin_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_ni,
  output logic [DATA_W-1:0] sr_o
);

  logic              sclk_prev_q;
  logic              shift_en;
  logic [DATA_W-1:0] sr_q;

  assign shift_en = sclk_i & ~sclk_prev_q & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (shift_en) sr_q <= {sr_q[DATA_W-2:0], sdi_i};
    end
  end

  assign sr_o = sr_q;

  // R2
  shift_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !sclk_i) |=> $stable(sr_q));

  // R1
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_prev_q && !cs_ni) |=> sr_q == {$past(sr_q[DATA_W-2:0]), $past(sdi_i)});

endmodule

// File: rtl/dac_fe_code_reg.sv
module dac_fe_code_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sr_i,
  input  logic              ld_ni,
  input  logic              clr_ni,
  input  logic              mid_sel_i,
  output logic [DATA_W-1:0] code_o
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] forced;

  assign forced = mid_sel_i ? MID_CODE : '0;

  // clear wins over load; load low is transparent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (!clr_ni) code_q <= forced;
    else if (!ld_ni)  code_q <= sr_i;
  end

  assign code_o = code_q;

  // R4
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && ld_ni) |=> $stable(code_q));

  // R3
  code_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !ld_ni) |=> code_q == $past(sr_i));

  // R5
  clr_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> code_q == ($past(mid_sel_i) ? MID_CODE : '0));

  // R6
  clr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !ld_ni && sr_i != forced) |=> code_q != $past(sr_i));

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_ni,
  input  logic              ld_a_ni,
  input  logic              ld_b_ni,
  input  logic              clr_ni,
  input  logic              mid_sel_i,
  input  logic              pd_ni,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic              pd_o
);

  localparam int PIN_W = $bits(pins_t);

  pins_t             pins_raw, pins_s;
  logic [DATA_W-1:0] sr;
  logic [NUM_CH-1:0] ld_n;
  logic [DATA_W-1:0] code [NUM_CH];

  assign pins_raw = '{sclk: sclk_i, sdi: sdi_i, cs_n: cs_ni, ld_a_n: ld_a_ni,
                      ld_b_n: ld_b_ni, clr_n: clr_ni, mid_sel: mid_sel_i, pd_n: pd_ni};

  dac_fe_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) pin_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  dac_fe_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_i(pins_s.sclk),
    .sdi_i (pins_s.sdi),
    .cs_ni (pins_s.cs_n),
    .sr_o  (sr)
  );

  assign ld_n = {pins_s.ld_b_n, pins_s.ld_a_n};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dac_fe_code_reg #(.DATA_W(DATA_W)) code_reg_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sr_i     (sr),
      .ld_ni    (ld_n[ch]),
      .clr_ni   (pins_s.clr_n),
      .mid_sel_i(pins_s.mid_sel),
      .code_o   (code[ch])
    );
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];
  assign pd_o     = ~pins_s.pd_n;

  // R6
  clr_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_s.clr_n |=> code_a_o == code_b_o);

endmodule

// File: tb/dual_dac_frontend_tb_top.sv
module dual_dac_frontend_tb_top;

  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, lda_n = 1'b1, ldb_n = 1'b1;
  logic clr_n = 1'b1, mid = 1'b0, pd_n = 1'b1;
  logic [11:0] a12, b12;
  logic [9:0]  a10, b10;
  logic        pd12, pd10;

  always #4 clk = ~clk;

  dual_dac_frontend #(.DATA_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_ni(cs_n),
    .ld_a_ni(lda_n), .ld_b_ni(ldb_n), .clr_ni(clr_n), .mid_sel_i(mid), .pd_ni(pd_n),
    .code_a_o(a12), .code_b_o(b12), .pd_o(pd12));

  dual_dac_frontend #(.DATA_W(10)) dut10_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_ni(cs_n),
    .ld_a_ni(lda_n), .ld_b_ni(ldb_n), .clr_ni(clr_n), .mid_sel_i(mid), .pd_ni(pd_n),
    .code_a_o(a10), .code_b_o(b10), .pd_o(pd10));

  int n_chk = 0, n_fail = 0, n_viol = 0;
  bit done = 0;

  // reference model
  logic [11:0] m_sr = '0, m_a = '0, m_b = '0;
  logic [9:0]  m_a10 = '0, m_b10 = '0;

  // protocol monitor: shifting into a transparent channel
  always @(posedge sclk) if (!cs_n && (!lda_n || !ldb_n)) n_viol++;

  task automatic apply();
    if (!clr_n) begin
      m_a = mid ? 12'h800 : 12'h000;  m_b = m_a;
      m_a10 = mid ? 10'h200 : 10'h000; m_b10 = m_a10;
    end else begin
      if (!lda_n) begin m_a = m_sr; m_a10 = m_sr[9:0]; end
      if (!ldb_n) begin m_b = m_sr; m_b10 = m_sr[9:0]; end
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " a12"}, a12, m_a);
    chk({tag, " b12"}, b12, m_b);
    chk({tag, " a10 R9"}, {2'b0, a10}, {2'b0, m_a10});
    chk({tag, " b10 R9"}, {2'b0, b10}, {2'b0, m_b10});
  endtask

  task automatic bit_in(logic b);
    sdi = b; settle();
    sclk = 1'b1;
    if (!cs_n) m_sr = {m_sr[10:0], b};
    apply(); settle();
    sclk = 1'b0; settle();
  endtask

  task automatic word_in(logic [11:0] w, logic sel);
    cs_n = sel; settle();
    for (int i = 11; i >= 0; i--) bit_in(w[i]);
    cs_n = 1'b1; settle();
  endtask

  task automatic load(logic do_a, logic do_b);
    lda_n = ~do_a; ldb_n = ~do_b; apply(); settle();
    lda_n = 1'b1; ldb_n = 1'b1; apply(); settle();
  endtask

  task automatic do_clr(logic m);
    mid = m; settle();
    clr_n = 1'b0; apply(); settle();
  endtask

  initial begin
    logic [11:0] w, saved;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 a", a12, 12'h0); chk("R10 b", b12, 12'h0);
    chk("R10 pd", {11'b0, pd12}, 12'h0);

    // R1 R3 R4 sweep: load A, B, both
    for (int k = 0; k < 24; k++) begin
      w = 12'((k * 12'h9E3 + 12'h015) ^ (k << 7));
      word_in(w, 1'b0);
      load(k % 3 != 1, k % 3 != 0);
      chk_all($sformatf("R1 R3 R4 k=%0d", k));
    end

    // R2 clocking while deselected
    saved = m_sr;
    word_in(12'h5A3 ^ saved, 1'b1);
    chk("R2 sr model", m_sr, saved);
    chk_all("R4 hold during gated clocking");
    load(1'b1, 1'b0);
    chk_all("R2 load after gated");

    // R5 mid-scale and zero, R7 shift kept
    word_in(12'hC3D, 1'b0);
    do_clr(1'b1);
    chk_all("R5 mid forced");
    clr_n = 1'b1; apply(); settle();
    chk_all("R5 mid kept");
    do_clr(1'b0);
    chk_all("R5 zero forced");
    // R6 load low during clear
    lda_n = 1'b0; ldb_n = 1'b0; apply(); settle();
    chk_all("R6 clear priority");
    lda_n = 1'b1; ldb_n = 1'b1; apply(); settle();
    clr_n = 1'b1; apply(); settle();
    chk_all("R5 zero kept");
    load(1'b0, 1'b1);
    chk("R7 b12 shift kept", b12, 12'hC3D);
    chk_all("R7 load after clear");

    // R8 power-down
    saved = a12;
    pd_n = 1'b0; settle();
    chk("R8 pd asserted", {11'b0, pd12}, 12'h1);
    chk("R8 pd10 asserted", {11'b0, pd10}, 12'h1);
    chk("R8 code unchanged", a12, saved);
    pd_n = 1'b1; settle();
    chk("R8 pd released", {11'b0, pd12}, 12'h0);
    load(1'b1, 1'b0);
    chk("R8 shift unchanged", a12, 12'hC3D);

    // R11 transparent during shifting
    chk("R11 no violation yet", 12'(n_viol), 12'h0);
    lda_n = 1'b0; apply(); settle();
    cs_n = 1'b0; settle();
    for (int i = 0; i < 5; i++) bit_in(i[0]);
    chk_all("R11 partial word follows");
    cs_n = 1'b1; settle();
    lda_n = 1'b1; apply(); settle();
    chk("R11 violations flagged", 12'(n_viol), 12'h5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule